// File: doc/BRIEF.md
# Network Injection Packet Buffer with Channel and Link Arbitration

This block sits at the network-bound side of a network interface. A writer hands it complete packets of up to `MAX_FLITS` flits in a single cycle. It keeps them in a small pool of packet slots. It then drives them onto one outgoing link, one flit per cycle. The outgoing link carries several virtual networks, and each virtual network has its own set of virtual channels. Downstream buffering is tracked with credits.

A waiting packet first needs an output virtual channel. Each virtual network has one round-robin arbiter over the slots. In each cycle it hands at most one idle channel of that network to one waiting packet. Only the head flit goes through this step, and the following flits reuse the channel. Packets that own a channel with a spare credit then compete in a single round-robin link arbiter. The winner's flit is registered onto the link. The slot returns to the free pool at the same edge that registers its tail flit. The channel becomes idle again at that edge as well.

Top module: `ni_inj_buffer`

## Requirements
- R1: After reset, `pkt_full` and `flit_valid` are low, every output channel is idle, and every channel holds `CRED_DEPTH` (4) credits. A lone 4-flit packet therefore leaves on four consecutive cycles with no credit returned.
- R2: A packet is accepted when `pkt_valid` is high and `pkt_full` is low, and it goes into a free slot. `pkt_full` is high exactly when all `N_SLOTS` slots are occupied. A write offered while `pkt_full` is high is dropped and never reaches the link.
- R3: In an otherwise idle block, the head flit of a packet is loaded into the output register two rising edges after the edge that accepted the write.
- R4: The flits of a packet leave in order, starting from flit 0 at `pkt_data[FLIT_W-1:0]` and rising, one per cycle when uncontested. `flit_head` marks the first flit and `flit_tail` the last; a one-flit packet carries both. All flits of a packet carry the same `flit_vc`.
- R5: Output channel numbering is `vnet*VC_PER_VNET + local index`. A head receives the lowest-numbered idle channel of its virtual network. Each network grants at most one channel per cycle. A channel stays with its packet until the tail flit is sent; only then can another packet of that network take it.
- R6: A flit is sent on a channel only while that channel's credit count is non-zero, and each flit sent takes one credit.
- R7: A `credit_valid` pulse adds one credit to channel `credit_vc`. If a packet is stalled only for credit, its next flit is registered at the edge after the edge that took the credit.
- R8: A slot is released at the edge that registers its tail flit, so `pkt_full` falls in the cycle in which that tail flit is on the output.
- R9: The link arbiter is round-robin, and the most recently granted slot has the lowest priority next. Two packets that both own channels with credit alternate flit by flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Packet write request |
| pkt_vnet | input | VNET_W | Virtual network of the offered packet |
| pkt_len | input | LEN_W | Flit count of the offered packet, 1 to MAX_FLITS |
| pkt_data | input | MAX_FLITS*FLIT_W | Packet payload, flit i at bits [i*FLIT_W +: FLIT_W] |
| pkt_full | output | 1 | No free slot; the write is not taken |
| flit_valid | output | 1 | A flit is on the link this cycle |
| flit_data | output | FLIT_W | Flit payload |
| flit_vc | output | VC_W | Output channel of the flit |
| flit_head | output | 1 | First flit of its packet |
| flit_tail | output | 1 | Last flit of its packet |
| credit_valid | input | 1 | One credit returned |
| credit_vc | input | VC_W | Channel the credit belongs to |

## Verification
The pipeline has two fixed delays. A head flit is due two edges after the write edge: one edge for channel allocation and one for link allocation into the output register. A flit stalled for credit is due one edge after the credit edge. `pkt_full` is due to fall in the same cycle in which the tail flit is shown. The bench stamps every flit it observes with the number of rising edges since its clock counter started. Each check then compares these stamps against the write or credit edge that the bench recorded. This keeps the checks independent of the sampling moment and of how many cycles the bench waits before looking.

// File: rtl/ni_inj_pkg.sv
// Shared types of the injection buffer.
// Assumes: nothing beyond the parameters of the modules that import it.
package ni_inj_pkg;

    // Life cycle of one packet slot
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT_VC = 2'd1,
        SLOT_ACTIVE = 2'd2
    } slot_state_e;

endpackage

// File: rtl/ni_rr_arb.sv
// Round-robin N:1 arbiter. The grant is one-hot, or zero when no requester.
// After any grant, the pointer moves to the slot just past the winner.
// Assumes: the grant is always consumed in the cycle it is given.
module ni_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] win;

    // Pick the first requester at or after the pointer
    always_comb begin
        logic found;
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(ptr_q) + i) % N;
            if (!found && req[j]) begin
                gnt[j] = 1'b1;
                win    = PW'(j);
                found  = 1'b1;
            end
        end
    end

    // Move the priority past the latest winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (|gnt) begin
            ptr_q <= (int'(win) == N - 1) ? '0 : win + PW'(1);
        end
    end

endmodule

// File: rtl/ni_vc_credit.sv
// Per output channel state: busy flag and downstream credit counter.
// Assumes: alloc_mask names only idle channels; a tail is sent only on a busy
// channel; credits are returned only for flits that were sent.
module ni_vc_credit #(
    parameter int N_VC       = 6,
    parameter int CRED_DEPTH = 4,
    parameter int VC_W       = (N_VC > 1) ? $clog2(N_VC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_VC-1:0] alloc_mask,
    input  logic            send_vld,
    input  logic [VC_W-1:0] send_vc,
    input  logic            send_tail,
    input  logic            ret_vld,
    input  logic [VC_W-1:0] ret_vc,
    output logic [N_VC-1:0] vc_idle,
    output logic [N_VC-1:0] vc_has_cred
);
    localparam int CW = $clog2(CRED_DEPTH + 1);

    logic [N_VC-1:0] busy_q;
    logic [CW-1:0]   cred_q [N_VC];

    // Set busy on allocation, clear it when the tail leaves; count credits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int v = 0; v < N_VC; v++) cred_q[v] <= CW'(CRED_DEPTH);
        end else begin
            for (int v = 0; v < N_VC; v++) begin
                logic inc, dec;
                inc = ret_vld && (ret_vc == VC_W'(v));
                dec = send_vld && (send_vc == VC_W'(v));
                if (alloc_mask[v]) busy_q[v] <= 1'b1;
                else if (dec && send_tail) busy_q[v] <= 1'b0;
                if (inc && !dec) cred_q[v] <= cred_q[v] + CW'(1);
                else if (dec && !inc) cred_q[v] <= cred_q[v] - CW'(1);
            end
        end
    end

    // Status seen by the allocators
    always_comb begin
        for (int v = 0; v < N_VC; v++) begin
            vc_idle[v]     = !busy_q[v];
            vc_has_cred[v] = (cred_q[v] != '0);
        end
    end

    AST_SEND_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        send_vld |-> (cred_q[send_vc] != '0)); // R6
    AST_SEND_ON_OWNED_VC: assert property (@(posedge clk) disable iff (!rst_n)
        send_vld |-> busy_q[send_vc]); // R5
    AST_CREDIT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld && !(send_vld && send_vc == ret_vc)) |-> (cred_q[ret_vc] < CW'(CRED_DEPTH))); // R7

    generate
        for (genvar g = 0; g < N_VC; g++) begin : g_chk
            AST_ALLOC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                alloc_mask[g] |-> !busy_q[g]); // R5
        end
    endgenerate

endmodule

// File: rtl/ni_inj_buffer.sv
// Injection buffer: packet slots, per-network channel allocation, link
// allocation and a registered flit output.
// Assumes: pkt_len is between 1 and MAX_FLITS and pkt_vnet is below N_VNET.
module ni_inj_buffer import ni_inj_pkg::*; #(
    parameter int N_SLOTS     = 4,
    parameter int N_VNET      = 3,
    parameter int VC_PER_VNET = 2,
    parameter int CRED_DEPTH  = 4,
    parameter int MAX_FLITS   = 4,
    parameter int FLIT_W      = 32,
    localparam int N_VC   = N_VNET * VC_PER_VNET,
    localparam int VC_W   = (N_VC > 1) ? $clog2(N_VC) : 1,
    localparam int VNET_W = (N_VNET > 1) ? $clog2(N_VNET) : 1,
    localparam int LEN_W  = $clog2(MAX_FLITS + 1),
    localparam int PKT_W  = MAX_FLITS * FLIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [VNET_W-1:0] pkt_vnet,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_full,
    output logic              flit_valid,
    output logic [FLIT_W-1:0] flit_data,
    output logic [VC_W-1:0]   flit_vc,
    output logic              flit_head,
    output logic              flit_tail,
    input  logic              credit_valid,
    input  logic [VC_W-1:0]   credit_vc
);
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    slot_state_e       st_q   [N_SLOTS];
    logic [VNET_W-1:0] vnet_q [N_SLOTS];
    logic [LEN_W-1:0]  len_q  [N_SLOTS];
    logic [LEN_W-1:0]  idx_q  [N_SLOTS];
    logic [VC_W-1:0]   vc_q   [N_SLOTS];
    logic [PKT_W-1:0]  data_q [N_SLOTS];

    logic              wr_ok, accept;
    logic [SLOT_W-1:0] wr_slot;
    logic [N_SLOTS-1:0] occ;

    logic [N_SLOTS-1:0] va_gnt [N_VNET];
    logic [VC_W-1:0]    va_pick [N_VNET];
    logic [N_SLOTS-1:0] va_win;
    logic [VC_W-1:0]    va_vc_s [N_SLOTS];
    logic [N_VC-1:0]    alloc_mask;

    logic [N_SLOTS-1:0] la_req, la_gnt;
    logic [SLOT_W-1:0]  la_sel;
    logic               send_vld, send_tail;
    logic [N_VC-1:0]    vc_idle, vc_has_cred;

    // Lowest free slot takes the next packet
    always_comb begin
        wr_ok   = 1'b0;
        wr_slot = '0;
        for (int s = N_SLOTS - 1; s >= 0; s--) begin
            if (st_q[s] == SLOT_FREE) begin
                wr_ok   = 1'b1;
                wr_slot = SLOT_W'(s);
            end
        end
    end

    assign pkt_full = !wr_ok;
    assign accept   = pkt_valid && wr_ok;

    // Occupancy map
    always_comb begin
        for (int s = 0; s < N_SLOTS; s++) occ[s] = (st_q[s] != SLOT_FREE);
    end

    // One channel arbiter per virtual network
    generate
        for (genvar v = 0; v < N_VNET; v++) begin : g_va
            logic               any_idle;
            logic [VC_W-1:0]    pick;
            logic [N_SLOTS-1:0] req;
            logic [N_SLOTS-1:0] gnt;

            // Lowest idle channel of this network
            always_comb begin
                any_idle = 1'b0;
                pick     = '0;
                for (int k = VC_PER_VNET - 1; k >= 0; k--) begin
                    if (vc_idle[v * VC_PER_VNET + k]) begin
                        any_idle = 1'b1;
                        pick     = VC_W'(v * VC_PER_VNET + k);
                    end
                end
            end

            // Slots of this network still waiting for a channel
            always_comb begin
                for (int s = 0; s < N_SLOTS; s++)
                    req[s] = (st_q[s] == SLOT_WAIT_VC) && (vnet_q[s] == VNET_W'(v)) && any_idle;
            end

            ni_rr_arb #(.N(N_SLOTS)) u_va_arb (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req),
                .gnt   (gnt)
            );

            assign va_gnt[v]  = gnt;
            assign va_pick[v] = pick;

            AST_VA_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(va_gnt[v])); // R5
        end
    endgenerate

    // Fold the per-network grants into per-slot and per-channel views
    always_comb begin
        va_win     = '0;
        alloc_mask = '0;
        for (int s = 0; s < N_SLOTS; s++) va_vc_s[s] = '0;
        for (int v = 0; v < N_VNET; v++) begin
            if (|va_gnt[v]) alloc_mask[va_pick[v]] = 1'b1;
            for (int s = 0; s < N_SLOTS; s++) begin
                if (va_gnt[v][s]) begin
                    va_win[s]  = 1'b1;
                    va_vc_s[s] = va_pick[v];
                end
            end
        end
    end

    // Link requests: channel owned and at least one credit on it
    always_comb begin
        for (int s = 0; s < N_SLOTS; s++)
            la_req[s] = (st_q[s] == SLOT_ACTIVE) && vc_has_cred[vc_q[s]];
    end

    ni_rr_arb #(.N(N_SLOTS)) u_la_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (la_req),
        .gnt   (la_gnt)
    );

    // Index of the link winner and whether it sends its tail
    always_comb begin
        la_sel = '0;
        for (int s = 0; s < N_SLOTS; s++) if (la_gnt[s]) la_sel = SLOT_W'(s);
        send_vld  = |la_gnt;
        send_tail = (idx_q[la_sel] + LEN_W'(1)) == len_q[la_sel];
    end

    ni_vc_credit #(
        .N_VC       (N_VC),
        .CRED_DEPTH (CRED_DEPTH),
        .VC_W       (VC_W)
    ) u_vc_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_mask  (alloc_mask),
        .send_vld    (send_vld),
        .send_vc     (vc_q[la_sel]),
        .send_tail   (send_tail),
        .ret_vld     (credit_valid),
        .ret_vc      (credit_vc),
        .vc_idle     (vc_idle),
        .vc_has_cred (vc_has_cred)
    );

    // Slot life cycle: load, take a channel, stream flits, release at tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOTS; s++) begin
                st_q[s]   <= SLOT_FREE;
                vnet_q[s] <= '0;
                len_q[s]  <= '0;
                idx_q[s]  <= '0;
                vc_q[s]   <= '0;
            end
        end else begin
            for (int s = 0; s < N_SLOTS; s++) begin
                if (accept && wr_slot == SLOT_W'(s)) begin
                    st_q[s]   <= SLOT_WAIT_VC;
                    vnet_q[s] <= pkt_vnet;
                    len_q[s]  <= pkt_len;
                    idx_q[s]  <= '0;
                    data_q[s] <= pkt_data;
                end else if (va_win[s]) begin
                    st_q[s] <= SLOT_ACTIVE;
                    vc_q[s] <= va_vc_s[s];
                end else if (la_gnt[s]) begin
                    if (send_tail) st_q[s] <= SLOT_FREE;
                    else idx_q[s] <= idx_q[s] + LEN_W'(1);
                end
            end
        end
    end

    // Output register for the link
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flit_valid <= 1'b0;
            flit_data  <= '0;
            flit_vc    <= '0;
            flit_head  <= 1'b0;
            flit_tail  <= 1'b0;
        end else begin
            flit_valid <= send_vld;
            flit_data  <= data_q[la_sel][int'(idx_q[la_sel]) * FLIT_W +: FLIT_W];
            flit_vc    <= vc_q[la_sel];
            flit_head  <= (idx_q[la_sel] == '0);
            flit_tail  <= send_tail;
        end
    end

    AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_full |=> ($countones(occ) <= $past($countones(occ)))); // R2
    AST_TAIL_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (send_vld && send_tail) |=> !pkt_full); // R8

endmodule

// File: tb/ni_inj_buffer_test.sv
`timescale 1ns/1ps
module ni_inj_buffer_test;
    localparam int N_SLOTS = 4, N_VNET = 3, VPV = 2, DEPTH = 4, MAXF = 4, FW = 32;
    localparam int VC_W = 3, VNET_W = 2, LEN_W = 3;

    // Stimulus/expectation table: [11:8] vnet, [7:4] expected channel, [3:0] length
    localparam logic [11:0] VEC [6] = '{
        {4'd0, 4'd0, 4'd1}, {4'd1, 4'd2, 4'd2}, {4'd2, 4'd4, 4'd4},
        {4'd0, 4'd0, 4'd3}, {4'd1, 4'd2, 4'd4}, {4'd2, 4'd4, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                 pkt_valid = 1'b0;
    logic [VNET_W-1:0]    pkt_vnet = '0;
    logic [LEN_W-1:0]     pkt_len = '0;
    logic [MAXF*FW-1:0]   pkt_data = '0;
    logic                 pkt_full, flit_valid, flit_head, flit_tail;
    logic [FW-1:0]        flit_data;
    logic [VC_W-1:0]      flit_vc;
    logic                 credit_valid;
    logic [VC_W-1:0]      credit_vc;
    logic                 man_cv = 1'b0, auto_cv = 1'b0, auto_en = 1'b0;
    logic [VC_W-1:0]      man_vc = '0, auto_cvc = '0;

    assign credit_valid = man_cv | auto_cv;
    assign credit_vc    = man_cv ? man_vc : auto_cvc;

    ni_inj_buffer #(
        .N_SLOTS(N_SLOTS), .N_VNET(N_VNET), .VC_PER_VNET(VPV),
        .CRED_DEPTH(DEPTH), .MAX_FLITS(MAXF), .FLIT_W(FW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_vnet(pkt_vnet),
        .pkt_len(pkt_len), .pkt_data(pkt_data), .pkt_full(pkt_full),
        .flit_valid(flit_valid), .flit_data(flit_data), .flit_vc(flit_vc),
        .flit_head(flit_head), .flit_tail(flit_tail),
        .credit_valid(credit_valid), .credit_vc(credit_vc)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Flit log, stamped with the edge count
    logic [FW-1:0]   lg_data [64];
    int              lg_cyc  [64];
    logic [VC_W-1:0] lg_vc   [64];
    logic            lg_head [64], lg_tail [64], lg_full [64], lg_fprev [64];
    int              lg_n = 0;
    logic            prev_full = 1'b0;

    always @(negedge clk) begin
        if (rst_n && flit_valid && lg_n < 64) begin
            lg_data[lg_n]  = flit_data;
            lg_cyc[lg_n]   = cyc;
            lg_vc[lg_n]    = flit_vc;
            lg_head[lg_n]  = flit_head;
            lg_tail[lg_n]  = flit_tail;
            lg_full[lg_n]  = pkt_full;
            lg_fprev[lg_n] = prev_full;
            lg_n = lg_n + 1;
        end
        auto_cv   <= auto_en && rst_n && flit_valid;
        auto_cvc  <= flit_vc;
        prev_full <= pkt_full;
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] word(input int tag, input int i);
        return 32'h5A00_0000 | (32'(tag) << 8) | 32'(i);
    endfunction

    function automatic int find(input int tag, input int i);
        for (int k = 0; k < lg_n; k++) if (lg_data[k] == word(tag, i)) return k;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pkt_valid = 1'b0; man_cv = 1'b0; auto_en = 1'b0;
        repeat (3) @(negedge clk);
        lg_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic write_pkt(input int vnet, input int len, input int tag, output int w);
        pkt_valid = 1'b1;
        pkt_vnet  = VNET_W'(vnet);
        pkt_len   = LEN_W'(len);
        for (int i = 0; i < MAXF; i++) pkt_data[i*FW +: FW] = word(tag, i);
        @(negedge clk);
        w = cyc;
        pkt_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int w, w2, c, a, d, vn, ev, ln;
        do_reset();
        chk(pkt_full == 1'b0, "R1 pkt_full after reset", pkt_full, 0);
        chk(flit_valid == 1'b0, "R1 flit_valid after reset", flit_valid, 0);

        // Table walk: one packet per vector into a freshly reset block
        for (int t = 0; t < 6; t++) begin
            vn = int'(VEC[t][11:8]); ev = int'(VEC[t][7:4]); ln = int'(VEC[t][3:0]);
            do_reset();
            auto_en = 1'b1;
            write_pkt(vn, ln, t + 1, w);
            repeat (12) @(negedge clk);
            chk(lg_n == ln, "R4 flit count", lg_n, ln);
            for (int i = 0; i < ln; i++) begin
                a = find(t + 1, i);
                chk(a >= 0, "R4 flit present in order", a, i);
                if (a >= 0) begin
                    chk(lg_cyc[a] == w + 2 + i, "R3 flit timing", lg_cyc[a], w + 2 + i);
                    chk(int'(lg_vc[a]) == ev, "R5 lowest idle channel", lg_vc[a], ev);
                    chk(lg_head[a] == (i == 0), "R4 head flag", lg_head[a], i == 0);
                    chk(lg_tail[a] == (i == ln - 1), "R4 tail flag", lg_tail[a], i == ln - 1);
                end
            end
        end

        // Fill all slots, offer one more, then drain
        do_reset();
        auto_en = 1'b1;
        for (int p = 1; p <= 4; p++) write_pkt(0, 4, p, w);
        chk(pkt_full == 1'b1, "R2 full with all slots used", pkt_full, 1);
        write_pkt(0, 4, 5, w);
        repeat (60) @(negedge clk);
        chk(lg_n == 16, "R2 flits drained", lg_n, 16);
        chk(find(5, 0) < 0, "R2 write while full dropped", find(5, 0), -1);
        for (int k = 0; k < 4; k++)
            chk(int'(lg_data[k][15:8]) == ((k % 2 == 0) ? 1 : 2), "R9 alternation",
                lg_data[k][15:8], (k % 2 == 0) ? 1 : 2);
        a = find(1, 0); d = find(2, 0);
        chk(a >= 0 && lg_vc[a] == 0, "R5 first packet channel", a >= 0 ? lg_vc[a] : -1, 0);
        chk(d >= 0 && lg_vc[d] == 1, "R5 second packet channel", d >= 0 ? lg_vc[d] : -1, 1);
        a = find(1, 3);
        chk(a >= 0 && lg_full[a] == 1'b0, "R8 full low with tail", a >= 0 ? lg_full[a] : -1, 0);
        chk(a >= 0 && lg_fprev[a] == 1'b1, "R8 full high before tail", a >= 0 ? lg_fprev[a] : -1, 1);
        d = find(3, 0);
        chk(a >= 0 && d >= 0 && lg_cyc[d] > lg_cyc[a], "R5 channel reused after tail",
            d >= 0 ? lg_cyc[d] : -1, a >= 0 ? lg_cyc[a] + 1 : -1);
        chk(d >= 0 && lg_vc[d] == 0, "R5 third packet takes freed channel", d >= 0 ? lg_vc[d] : -1, 0);
        chk(pkt_full == 1'b0, "R2 not full after drain", pkt_full, 0);

        // Credit exhaustion and return on channel 4
        do_reset();
        write_pkt(2, 4, 20, w);
        repeat (8) @(negedge clk);
        a = find(20, 0); d = find(20, 3);
        chk(a >= 0 && lg_cyc[a] == w + 2, "R1 head with reset credits", a >= 0 ? lg_cyc[a] : -1, w + 2);
        chk(d >= 0 && lg_cyc[d] == w + 5, "R1 four credits at reset", d >= 0 ? lg_cyc[d] : -1, w + 5);
        write_pkt(2, 4, 21, w2);
        repeat (10) @(negedge clk);
        chk(find(21, 0) < 0, "R6 no flit without credit", find(21, 0), -1);
        man_vc = 3'd4; man_cv = 1'b1;
        @(negedge clk);
        c = cyc; man_cv = 1'b0;
        repeat (5) @(negedge clk);
        a = find(21, 0);
        chk(a >= 0 && lg_cyc[a] == c + 1, "R7 resume one edge after credit", a >= 0 ? lg_cyc[a] : -1, c + 1);
        chk(a >= 0 && lg_vc[a] == 4, "R5 freed lowest channel reused", a >= 0 ? lg_vc[a] : -1, 4);
        chk(find(21, 1) < 0, "R6 one credit one flit", find(21, 1), -1);
        man_cv = 1'b1;
        repeat (3) @(negedge clk);
        man_cv = 1'b0;
        repeat (6) @(negedge clk);
        d = find(21, 3);
        chk(d >= 0 && lg_tail[d] == 1'b1, "R7 packet completes after credits", d, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule